// File: doc/BRIEF.md
# Dual-Mode Converter Bus Interface

This block is the digital front end of an 8-bit sampling converter that hangs on a microprocessor bus. It owns the hold control for the sampler, a cycle-counted conversion sequence, the result and over-range registers, an active-low completion interrupt, and the bus-side enables for the data lines and for a shared strobe/ready pin. The analog sampler and comparator array sit outside; the block receives their 8-bit code and an over-range bit and captures both on the final cycle of each conversion.

A static mode input picks one of two access styles. With the mode input high (write-then-read), a falling edge on the shared pin starts a conversion, and a later read fetches the result. With the mode input low (read-starts), a falling read strobe both returns the previous result and launches the next conversion. In that mode the shared pin becomes an open-drain busy line: the block pulls it low for the whole conversion and lets an external pull-up raise it afterwards. All strobes pass through a two-flop synchroniser and are acted on at their synchronised falling edges, and only while the synchronised chip select is low.

Top module: `adc_bus_if`

## Requirements
- R1: With `mode_wr_rd` = 1 and `cs_n` low, a falling edge on `wr_rdy_in` raises `hold` for exactly `CONV_CYCLES` clock cycles; a read strobe alone in this mode starts nothing.
- R2: With `mode_wr_rd` = 0 and `cs_n` low, a falling edge on `rd_n` raises `hold` for exactly `CONV_CYCLES` cycles, and `rdy_oe` is 1 in exactly the cycles where `hold` is 1; `rdy_o` is always 0.
- R3: With `mode_wr_rd` = 1, `rdy_oe` stays 0; with `mode_wr_rd` = 0, falling edges on `wr_rdy_in` start no conversion.
- R4: `int_n` goes to 0 in the cycle `hold` falls and returns to 1 after a synchronised falling edge of `rd_n` with `cs_n` low; it stays 0 otherwise.
- R5: `data_oe` is 1 exactly while both `cs_n` and `rd_n` are 0, and `data_o` carries the code captured by the most recent finished conversion (bit 0 least significant).
- R6: While `cs_n` is 1, falling edges on `rd_n` and `wr_rdy_in` neither start a conversion nor clear `int_n`.
- R7: `ovf_n` equals the inverse of `conv_over` as sampled in the final conversion cycle, and changes only when a conversion finishes.
- R8: A start strobe that arrives while `hold` is 1 is ignored: the running conversion keeps its length and no second conversion follows.
- R9: After reset, `hold` = 0, `int_n` = 1, `ovf_n` = 1, `rdy_oe` = 0 and `data_o` = 0.
- R10: `data_o` takes the value present on `conv_code` in the final cycle of the conversion, not the value present at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_rd | input | 1 | Static access mode: 1 write-then-read, 0 read-starts |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_rdy_in | input | 1 | Level sensed on the shared strobe/ready pin |
| conv_code | input | DATA_W | Code from the comparator array |
| conv_over | input | 1 | Input above full scale (reference difference) |
| hold | output | 1 | Sampler in hold / conversion running |
| int_n | output | 1 | Conversion-complete interrupt, active low |
| ovf_n | output | 1 | Over-range flag, active low |
| rdy_oe | output | 1 | Enable of the open-drain driver on the shared pin |
| rdy_o | output | 1 | Drive value of the shared pin (constant 0) |
| data_oe | output | 1 | Data bus drive enable |
| data_o | output | DATA_W | Result code |

## Verification
The hardest case to reach is a start strobe that lands inside a running conversion, since the strobe's effect is delayed by the synchroniser and the conversion is short. The bench watches `hold` cycle by cycle and drops the strobe again at a fixed count into the conversion, changing `conv_code` at the same point, so both the ignored restart and the end-of-conversion capture are exercised on one conversion. The read-starts mode is also driven through a wired-AND pin model so that another bus agent can pull the shared pin low while the block ignores it.

// File: rtl/adcbus_pkg.sv
package adcbus_pkg;

    typedef enum logic {
        MODE_RD_ONLY = 1'b0,
        MODE_WR_RD   = 1'b1
    } access_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } conv_state_e;

    // bit positions of the strobes inside the synchroniser vector
    localparam int STB_WR  = 0;
    localparam int STB_RD  = 1;
    localparam int STB_CS  = 2;
    localparam int STB_NUM = 3;

    // which synchronised falling edge counts as a conversion start
    function automatic logic start_edge(input access_mode_e mode,
                                        input logic wr_fall,
                                        input logic rd_fall);
        return (mode == MODE_WR_RD) ? wr_fall : rd_fall;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] level,
    output logic [N-1:0] fall
);
    for (genvar g = 0; g < N; g++) begin : g_chain
        logic s1, s2, s3;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b1;
                s2 <= 1'b1;
                s3 <= 1'b1;
            end else begin
                s1 <= raw[g];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign level[g] = s2;
        assign fall[g]  = s3 & ~s2;
    end
endmodule

// File: rtl/conv_engine.sv
module conv_engine
    import adcbus_pkg::*;
#(
    parameter int CONV_CYCLES = 20,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] code_in,
    input  logic              over_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] code_q,
    output logic              over_q
);
    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

    conv_state_e st;
    logic [CW-1:0] cnt;

    assign busy = (st == ST_BUSY);
    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            code_q <= '0;
            over_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st  <= ST_BUSY;
                        cnt <= LOAD;
                    end
                end
                ST_BUSY: begin
                    if (cnt == '0) begin
                        st     <= ST_IDLE;
                        code_q <= code_in;
                        over_q <= over_in;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10
    code_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_q) |-> $past(done));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> busy);
endmodule

// File: rtl/adc_bus_if.sv
module adc_bus_if
    import adcbus_pkg::*;
#(
    parameter int CONV_CYCLES = 20,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr_rd,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_rdy_in,
    input  logic [DATA_W-1:0] conv_code,
    input  logic              conv_over,
    output logic              hold,
    output logic              int_n,
    output logic              ovf_n,
    output logic              rdy_oe,
    output logic              rdy_o,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_o
);
    access_mode_e mode;
    logic [STB_NUM-1:0] raw, lvl, fall;
    logic sel_q, start, read_ev, busy, done, over_q;

    assign mode = access_mode_e'(mode_wr_rd);
    assign raw[STB_WR] = wr_rdy_in;
    assign raw[STB_RD] = rd_n;
    assign raw[STB_CS] = cs_n;

    strobe_sync #(.N(STB_NUM)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (raw),
        .level (lvl),
        .fall  (fall)
    );

    assign sel_q   = ~lvl[STB_CS];
    assign read_ev = sel_q && fall[STB_RD];
    assign start   = sel_q && start_edge(mode, fall[STB_WR], fall[STB_RD]);

    conv_engine #(.CONV_CYCLES(CONV_CYCLES), .DATA_W(DATA_W)) u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .code_in (conv_code),
        .over_in (conv_over),
        .busy    (busy),
        .done    (done),
        .code_q  (data_o),
        .over_q  (over_q)
    );

    // interrupt flag: completion wins over a simultaneous read
    always_ff @(posedge clk) begin
        if (rst)          int_n <= 1'b1;
        else if (done)    int_n <= 1'b0;
        else if (read_ev) int_n <= 1'b1;
    end

    assign hold    = busy;
    assign ovf_n   = ~over_q;
    assign rdy_oe  = (mode == MODE_RD_ONLY) && busy;
    assign rdy_o   = 1'b0;
    assign data_oe = ~cs_n & ~rd_n;

    // R3
    rdy_mode_chk: assert property (@(posedge clk) disable iff (rst)
        rdy_oe |-> (mode_wr_rd == 1'b0));

    // R4
    int_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> $fell(hold));

    // R6
    start_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> $past(lvl[STB_CS]) == 1'b0);

    // R7
    ovf_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ovf_n) |-> $fell(hold));
endmodule

// File: tb/test_adc_bus_if.sv
module test_adc_bus_if;
    localparam int CONV = 6;
    localparam int DW   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_wr_rd = 1'b1;
    logic cs_n = 1'b0;
    logic rd_n = 1'b1;
    logic wr_drv = 1'b1;
    logic [DW-1:0] conv_code = '0;
    logic conv_over = 1'b0;
    logic hold, int_n, ovf_n, rdy_oe, rdy_o, data_oe;
    logic [DW-1:0] data_o;
    logic wr_pin;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // wired-AND shared pin: bus agent drive, open-drain pull-down, pull-up
    assign wr_pin = wr_drv & ~(rdy_oe & ~rdy_o);

    adc_bus_if #(.CONV_CYCLES(CONV), .DATA_W(DW)) i_adc_bus_if (
        .clk(clk), .rst(rst), .mode_wr_rd(mode_wr_rd), .cs_n(cs_n),
        .rd_n(rd_n), .wr_rdy_in(wr_pin), .conv_code(conv_code),
        .conv_over(conv_over), .hold(hold), .int_n(int_n), .ovf_n(ovf_n),
        .rdy_oe(rdy_oe), .rdy_o(rdy_o), .data_oe(data_oe), .data_o(data_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(4);
        rst = 1'b0;
        tick(1);
        // R9 reset state
        chk(hold == 0 && int_n == 1 && ovf_n == 1 && rdy_oe == 0, "R9",
            {hold, int_n, ovf_n, rdy_oe}, 4'b0110);
        chk(data_o == 0, "R9 data", data_o, 0);
    endtask

    // wait for hold, then count the cycles it stays high
    task automatic measure(output int len, output int rdy_bad);
        len = 0;
        rdy_bad = 0;
        for (int i = 0; i < 12 && !hold; i++) tick(1);
        while (hold && len < 100) begin
            len++;
            if (rdy_oe != (mode_wr_rd ? 1'b0 : 1'b1)) rdy_bad++;
            tick(1);
        end
    endtask

    task automatic count_hold(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            if (hold) seen++;
            tick(1);
        end
    endtask

    task automatic conv_wr(input int v, input bit ov);
        int len, bad, seen;
        conv_code = DW'(v);
        conv_over = ov;
        wr_drv = 1'b0;
        measure(len, bad);
        wr_drv = 1'b1;
        chk(len == CONV, "R1 length", len, CONV);
        chk(bad == 0, "R3 rdy_oe in write-read", bad, 0);
        chk(int_n == 0, "R4 int set", int_n, 0);
        chk(ovf_n == !ov, "R7", ovf_n, !ov);
        rd_n = 1'b0;
        #1;
        chk(data_oe == 1, "R5 oe", data_oe, 1);
        chk(data_o == DW'(v), "R5 data", data_o, v);
        count_hold(5, seen);
        chk(seen == 0, "R1 read starts nothing", seen, 0);
        chk(int_n == 1, "R4 int clear", int_n, 1);
        rd_n = 1'b1;
        #1;
        chk(data_oe == 0, "R5 oe off", data_oe, 0);
        tick(3);
    endtask

    task automatic conv_rd(input int v, input bit ov, input int prev);
        int len, bad;
        conv_code = DW'(v);
        conv_over = ov;
        rd_n = 1'b0;
        #1;
        chk(data_oe == 1 && data_o == DW'(prev), "R5 previous data", data_o, prev);
        measure(len, bad);
        rd_n = 1'b1;
        chk(len == CONV, "R2 length", len, CONV);
        chk(bad == 0 && rdy_o == 0, "R2 rdy_oe tracks hold", bad, 0);
        chk(int_n == 0, "R4 int set", int_n, 0);
        chk(ovf_n == !ov, "R7", ovf_n, !ov);
        tick(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int len, bad, seen, prev;
        do_reset();

        // write-then-read mode: every code value
        for (int v = 0; v < 256; v++) conv_wr(v, (v % 3) == 0);

        // R8 / R10: restart strobe mid-conversion, code changes mid-conversion
        conv_code = 8'h5A;
        conv_over = 1'b0;
        wr_drv = 1'b0;
        for (int i = 0; i < 12 && !hold; i++) tick(1);
        len = 0;
        while (hold && len < 100) begin
            len++;
            if (len == 2) begin wr_drv = 1'b1; conv_code = 8'hA5; end
            if (len == 3) wr_drv = 1'b0;
            tick(1);
        end
        wr_drv = 1'b1;
        chk(len == CONV, "R8 length kept", len, CONV);
        count_hold(12, seen);
        chk(seen == 0, "R8 no second conversion", seen, 0);
        rd_n = 1'b0;
        #1;
        chk(data_o == 8'hA5, "R10 end-of-conversion code", data_o, 8'hA5);
        tick(5);
        rd_n = 1'b1;
        tick(3);

        // R6: chip select high blocks strobes and interrupt clear
        conv_code = 8'h33;
        wr_drv = 1'b0;
        measure(len, bad);
        wr_drv = 1'b1;
        chk(int_n == 0, "R6 setup", int_n, 0);
        cs_n = 1'b1;
        tick(3);
        rd_n = 1'b0;
        wr_drv = 1'b0;
        #1;
        chk(data_oe == 0, "R6 data_oe", data_oe, 0);
        count_hold(4, seen);
        rd_n = 1'b1;
        wr_drv = 1'b1;
        tick(2);
        rd_n = 1'b0;
        wr_drv = 1'b0;
        count_hold(8, bad);
        seen += bad;
        chk(seen == 0, "R6 no conversion", seen, 0);
        chk(int_n == 0, "R6 int kept", int_n, 0);
        rd_n = 1'b1;
        wr_drv = 1'b1;
        tick(4);
        cs_n = 1'b0;
        tick(4);
        chk(int_n == 0 && hold == 0, "R6 cs return no event", int_n, 0);

        // read-starts mode
        mode_wr_rd = 1'b0;
        do_reset();
        // R3: another agent pulls the shared pin low
        wr_drv = 1'b0;
        count_hold(4, seen);
        wr_drv = 1'b1;
        count_hold(8, bad);
        chk(seen + bad == 0, "R3 shared pin ignored", seen + bad, 0);
        prev = 0;
        for (int v = 0; v < 256; v++) begin
            int code = (v * 37 + 11) % 256;
            conv_rd(code, (v % 5) == 1, prev);
            prev = code;
        end
        // a read strobe clears the interrupt as it starts the next conversion
        rd_n = 1'b0;
        #1;
        chk(data_o == DW'(prev), "R5 last data", data_o, prev);
        tick(4);
        chk(int_n == 1 && hold == 1, "R4 clear on read", {int_n, hold}, 3);
        rd_n = 1'b1;
        tick(3 * CONV);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule